// File: doc/BRIEF.md
# PCI Target Write Burst Segmenter

This block sits on the write path of a bus bridge, between a 32-bit PCI target front end and a memory-mapped write master. The front end hands it one memory-write data beat per cycle. The first beat of a transaction carries the start flag, the selected base-address window and the byte address. Every beat carries the bus command, a data word, its byte enables and a last flag. The block cuts each burst into pieces that never straddle an aligned 32-byte block. It stages the words in a shared word buffer. A piece becomes eligible for the master only once its descriptor is committed to a separate descriptor queue.

The master side replays each committed piece as one burst. The start address and the burst length are held for the whole burst, and the word stream pauses under `m_waitrequest`. The block also tells the front end when to end the transaction, through a combinational disconnect request. This happens when the incoming beat is the last one the buffer can take, when the buffer is already full, or when the burst asked for cacheline-wrap ordering.

Top module: `pci_wr_segmenter`

## Requirements
- R1: Beats with command 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) are processed identically. Beats with any other command code are ignored: nothing is stored, nothing is issued and `t_disc` stays low.
- R2: A burst's first master-side address equals the start address with bits [1:0] cleared. Each later piece starts at the word after the previous piece. `m_bar` repeats the window index taken from the start beat.
- R3: No master burst crosses a 32-byte block: address bits [4:2] plus `m_burstcount` never exceed 8.
- R4: A piece is committed on the beat whose word address has bits [4:2] = 3'b111, so an aligned 8-beat transfer yields exactly one 8-word burst.
- R5: A master burst begins only after its piece is committed. `m_burstcount` equals the number of committed words. Words leave in arrival order, and no word is issued that was not accepted.
- R6: A start beat whose address bits [1:0] are 2'b10 (cacheline wrap order) raises `t_disc` with that beat. It is committed as a one-word piece, and later non-start beats are ignored.
- R7: Byte enables reach `m_byteenable` unchanged. A beat with byte enables 4'b0000 does not end the piece.
- R8: A transaction ended by `t_last` before a 32-byte boundary commits its open piece at its current length.
- R9: `t_disc` is high while a start or in-transaction beat is presented with at most one free buffer word. A beat offered with one free word is accepted and commits its piece. A beat offered with none is not stored.
- R10: While `m_write` and `m_waitrequest` are both high, the next cycle keeps `m_write` high and holds `m_address`, `m_burstcount`, `m_bar`, `m_writedata` and `m_byteenable` unchanged.
- R11: During and just after reset, `m_write` and `t_disc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t_valid | input | 1 | A data beat is presented this cycle |
| t_start | input | 1 | Beat is the first of a transaction |
| t_bar | input | 3 | Base-address window index (start beat) |
| t_addr | input | 32 | Byte address (start beat); bits [1:0] give burst order |
| t_cmd | input | 4 | Bus command of the transaction |
| t_data | input | 32 | Write data word |
| t_be | input | 4 | Byte enables, active high |
| t_last | input | 1 | Beat is the final one the front end offers |
| t_disc | output | 1 | Disconnect request to the front end |
| m_write | output | 1 | Master write beat valid |
| m_address | output | 32 | Byte address of the current burst |
| m_bar | output | 3 | Window index of the current burst |
| m_burstcount | output | 4 | Words in the current burst |
| m_writedata | output | 32 | Write data of the current beat |
| m_byteenable | output | 4 | Byte enables of the current beat |
| m_waitrequest | input | 1 | Slave stalls the current beat |

## Verification
Suppose the open-piece counter or the next-word address goes wrong. The burst address or length on the master side then differs from the reference on the first beat of the affected burst, which follows the commit by two cycles. If the buffer occupancy is wrong, `t_disc` differs from the model in the very cycle the beat is offered, or at the latest once the buffer nears full. A broken commit gate shows up as a master beat for which the model holds no committed piece. The model follows occupancy only through beats seen at the ports, so a stalled or lost word also leaves the final queues non-empty.

// File: rtl/pws_pkg.sv
// Package: shared widths, command codes and record types for the write
// burst segmenter. Assumes a 32-bit data path and 32-byte pieces.
package pws_pkg;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BE_W      = DATA_W / 8;
    localparam int unsigned BAR_W     = 3;
    localparam int unsigned PIECE_B   = 32;
    localparam int unsigned PIECE_W   = PIECE_B / BE_W;
    localparam int unsigned CNT_W     = $clog2(PIECE_W + 1);
    localparam int unsigned OFS_W     = $clog2(PIECE_W);
    localparam int unsigned LSB_W     = $clog2(BE_W);
    localparam int unsigned WA_W      = ADDR_W - LSB_W;

    localparam logic [3:0] CMD_MEMWR  = 4'b0111;
    localparam logic [3:0] CMD_MEMWRI = 4'b1111;
    localparam logic [1:0] ORDER_WRAP = 2'b10;

    // one staged data word with its lane enables
    typedef struct packed {
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } word_t;

    // one committed piece: window, first word address, word count
    typedef struct packed {
        logic [BAR_W-1:0] bar;
        logic [WA_W-1:0]  waddr;
        logic [CNT_W-1:0] cnt;
    } desc_t;
endpackage

// File: rtl/pws_fifo.sv
// Module: synchronous first-word-fall-through queue.
// Assumes DEPTH is a power of two and that the owner never pushes when
// full or pops when empty; both are guarded below.
module pws_fifo #(
    parameter int unsigned WIDTH = 36,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // head of queue is visible without a read cycle
    assign rdata = mem[rptr];

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/pws_seg_builder.sv
// Module: ingress side. Accepts memory-write beats, tracks the open piece,
// closes it at a 32-byte boundary, on the front end's last beat or on a
// disconnect, and produces the disconnect request. Assumes the front end
// obeys the disconnect and never starts a transaction while one is open.
module pws_seg_builder
    import pws_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic [BAR_W-1:0]  in_bar,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [3:0]        in_cmd,
    input  logic [DATA_W-1:0] in_data,
    input  logic [BE_W-1:0]   in_be,
    input  logic              in_last,
    input  logic [CW-1:0]     free_words,
    output logic              disc_req,
    output logic              word_push,
    output word_t             word,
    output logic              desc_push,
    output desc_t             desc
);
    logic             xfer_act;
    logic             seg_open;
    logic [BAR_W-1:0] xfer_bar;
    logic [WA_W-1:0]  nxt_waddr;
    logic [WA_W-1:0]  seg_waddr;
    logic [CNT_W-1:0] seg_cnt;

    logic             cmd_ok;
    logic             takes;
    logic             wrap_start;
    logic             seg_first;
    logic             boundary;
    logic             final_beat;
    logic [WA_W-1:0]  beat_waddr;

    // classify the presented beat
    always_comb begin
        cmd_ok     = (in_cmd == CMD_MEMWR) || (in_cmd == CMD_MEMWRI);
        takes      = in_valid && cmd_ok && (in_start || xfer_act);
        wrap_start = in_start && (in_addr[LSB_W-1:0] == ORDER_WRAP);
        disc_req   = takes && ((free_words <= CW'(1)) || wrap_start);
        word_push  = takes && (free_words != '0);
        beat_waddr = in_start ? in_addr[ADDR_W-1:LSB_W] : nxt_waddr;
        seg_first  = in_start || !seg_open;
        boundary   = &beat_waddr[OFS_W-1:0];
        final_beat = in_last || disc_req;
        desc_push  = word_push && (boundary || final_beat);
    end

    // descriptor and staged word for the beat being accepted
    always_comb begin
        word.data  = in_data;
        word.be    = in_be;
        desc.bar   = in_start ? in_bar : xfer_bar;
        desc.waddr = seg_first ? beat_waddr : seg_waddr;
        desc.cnt   = seg_first ? CNT_W'(1) : seg_cnt + 1'b1;
    end

    // transaction and open-piece state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_act  <= 1'b0;
            seg_open  <= 1'b0;
            xfer_bar  <= '0;
            nxt_waddr <= '0;
            seg_waddr <= '0;
            seg_cnt   <= '0;
        end else if (word_push) begin
            xfer_act  <= !final_beat;
            seg_open  <= !desc_push;
            nxt_waddr <= beat_waddr + 1'b1;
            seg_cnt   <= desc.cnt;
            if (in_start)  xfer_bar  <= in_bar;
            if (seg_first) seg_waddr <= beat_waddr;
        end
    end

    p_seg_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_push |-> ((CNT_W'(desc.waddr[OFS_W-1:0]) + desc.cnt) <= CNT_W'(PIECE_W)));
    p_wrap_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_push && wrap_start) |-> (desc_push && desc.cnt == CNT_W'(1) && disc_req));
    p_term_commits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_push && in_last) |-> desc_push);
    p_no_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_push && disc_req) |=> !(in_valid && !in_start && word_push));
endmodule

// File: rtl/pws_burst_master.sv
// Module: egress side. Takes one committed descriptor at a time and streams
// its words to the memory-mapped slave, stalling on waitrequest. Assumes
// every committed descriptor's words are already in the word queue.
module pws_burst_master
    import pws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cq_valid,
    input  desc_t             cq_desc,
    output logic              cq_pop,
    input  logic              dq_valid,
    input  word_t             dq_word,
    output logic              dq_pop,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_address,
    output logic [BAR_W-1:0]  m_bar,
    output logic [CNT_W-1:0]  m_burstcount,
    output logic [DATA_W-1:0] m_writedata,
    output logic [BE_W-1:0]   m_byteenable,
    input  logic              m_waitrequest
);
    logic             busy;
    logic [CNT_W-1:0] rem;
    desc_t            cur;

    // load a descriptor when idle, retire a word per accepted beat
    always_comb begin
        cq_pop = !busy && cq_valid;
        dq_pop = busy && !m_waitrequest;
    end

    // burst state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            rem  <= '0;
            cur  <= '0;
        end else if (cq_pop) begin
            busy <= 1'b1;
            rem  <= cq_desc.cnt;
            cur  <= cq_desc;
        end else if (dq_pop) begin
            rem <= rem - 1'b1;
            if (rem == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // port view of the burst
    always_comb begin
        m_write      = busy;
        m_address    = {cur.waddr, {LSB_W{1'b0}}};
        m_bar        = cur.bar;
        m_burstcount = cur.cnt;
        m_writedata  = dq_word.data;
        m_byteenable = dq_word.be;
    end

    p_hold_on_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(m_address) &&
            $stable(m_burstcount) && $stable(m_writedata) && $stable(m_byteenable)));
    p_issue_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_write) |-> $past(cq_valid));
    p_beat_has_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> dq_valid);
endmodule

// File: rtl/pci_wr_segmenter.sv
// Module: top of the write burst segmenter. Joins the ingress builder, a
// shared word queue, a descriptor queue that forms the commit point, and the
// burst master. Assumes BUF_WORDS is a power of two, at least 2.
module pci_wr_segmenter
    import pws_pkg::*;
#(
    parameter int unsigned BUF_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t_valid,
    input  logic              t_start,
    input  logic [BAR_W-1:0]  t_bar,
    input  logic [ADDR_W-1:0] t_addr,
    input  logic [3:0]        t_cmd,
    input  logic [DATA_W-1:0] t_data,
    input  logic [BE_W-1:0]   t_be,
    input  logic              t_last,
    output logic              t_disc,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_address,
    output logic [BAR_W-1:0]  m_bar,
    output logic [CNT_W-1:0]  m_burstcount,
    output logic [DATA_W-1:0] m_writedata,
    output logic [BE_W-1:0]   m_byteenable,
    input  logic              m_waitrequest
);
    localparam int unsigned CW = $clog2(BUF_WORDS) + 1;

    logic          w_push, w_pop, d_push, d_pop;
    word_t         w_in, w_out;
    desc_t         d_in, d_out;
    logic [CW-1:0] w_count, d_count, w_free;

    // free words seen by the ingress side
    assign w_free = CW'(BUF_WORDS) - w_count;

    pws_seg_builder #(.CW(CW)) u_build (
        .clk(clk), .rst_n(rst_n),
        .in_valid(t_valid), .in_start(t_start), .in_bar(t_bar),
        .in_addr(t_addr), .in_cmd(t_cmd), .in_data(t_data), .in_be(t_be),
        .in_last(t_last), .free_words(w_free), .disc_req(t_disc),
        .word_push(w_push), .word(w_in), .desc_push(d_push), .desc(d_in)
    );

    pws_fifo #(.WIDTH($bits(word_t)), .DEPTH(BUF_WORDS)) u_words (
        .clk(clk), .rst_n(rst_n), .push(w_push), .wdata(w_in),
        .pop(w_pop), .rdata(w_out), .count(w_count)
    );

    pws_fifo #(.WIDTH($bits(desc_t)), .DEPTH(BUF_WORDS)) u_descs (
        .clk(clk), .rst_n(rst_n), .push(d_push), .wdata(d_in),
        .pop(d_pop), .rdata(d_out), .count(d_count)
    );

    pws_burst_master u_mst (
        .clk(clk), .rst_n(rst_n),
        .cq_valid(d_count != '0), .cq_desc(d_out), .cq_pop(d_pop),
        .dq_valid(w_count != '0), .dq_word(w_out), .dq_pop(w_pop),
        .m_write(m_write), .m_address(m_address), .m_bar(m_bar),
        .m_burstcount(m_burstcount), .m_writedata(m_writedata),
        .m_byteenable(m_byteenable), .m_waitrequest(m_waitrequest)
    );

    p_disc_needs_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        t_disc |-> t_valid);
endmodule

// File: tb/pci_wr_segmenter_bench.sv
`timescale 1ns/1ps
module pci_wr_segmenter_bench;
    localparam int BUF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t_valid = 1'b0, t_start = 1'b0, t_last = 1'b0;
    logic [2:0]  t_bar = '0;
    logic [31:0] t_addr = '0, t_data = '0;
    logic [3:0]  t_cmd = '0, t_be = '0;
    logic        t_disc, m_write, m_waitrequest = 1'b0;
    logic [31:0] m_address, m_writedata;
    logic [2:0]  m_bar;
    logic [3:0]  m_burstcount, m_byteenable;

    pci_wr_segmenter #(.BUF_WORDS(BUF)) u_pci_wr_segmenter (.*);

    always #2.5 clk = ~clk;

    typedef struct packed { logic [31:0] a; logic [3:0] n; logic [2:0] bar; } seg_t;
    typedef struct packed { logic [3:0] be; logic [31:0] d; } wrd_t;
    seg_t exp_segs[$];
    wrd_t exp_words[$];

    int checks = 0, errors = 0, bursts = 0;
    int pushed = 0, popped = 0;
    int wait_mode = 0;
    logic [7:0] lf = 8'h5A;
    logic [31:0] seed = 32'hA000_0000;

    // reference state: transaction active, next word, open piece
    bit          r_act = 0;
    int          r_open = 0;
    logic [29:0] r_nw = '0, r_seg = '0;
    logic [2:0]  r_bar = '0;
    int          beat_in_burst = 0;
    bit          prev_hold = 0;
    logic [31:0] p_a, p_d;
    logic [3:0]  p_n, p_be;
    logic [2:0]  p_bar;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slave stall pattern, changed away from the clock edge
    always @(posedge clk) begin
        #1;
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        m_waitrequest = (wait_mode == 0) ? 1'b0 : (wait_mode == 2) ? 1'b1 : lf[0];
    end

    // reference model and comparison, once per cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit cmd_ok, takes, wrap, dexp, acc, fin;
            int fr;
            logic [29:0] w;
            if (prev_hold)
                chk(m_write && m_address == p_a && m_burstcount == p_n && m_bar == p_bar &&
                    m_writedata == p_d && m_byteenable == p_be, "R10", "hold under wait",
                    m_address, p_a);
            fr     = BUF - (pushed - popped);
            cmd_ok = (t_cmd == 4'b0111) || (t_cmd == 4'b1111);
            takes  = t_valid && cmd_ok && (t_start || r_act);
            wrap   = t_start && (t_addr[1:0] == 2'b10);
            dexp   = takes && (fr <= 1 || wrap);
            acc    = takes && fr > 0;
            if (t_valid) chk(t_disc == dexp, wrap ? "R6" : (cmd_ok ? "R9" : "R1"),
                             "disconnect", t_disc, dexp);
            if (acc) begin
                w = t_start ? t_addr[31:2] : r_nw;
                if (t_start) r_bar = t_bar;
                if (t_start || r_open == 0) begin r_seg = w; r_open = 0; end
                exp_words.push_back({t_be, t_data});
                r_open++;
                pushed++;
                r_nw = w + 1;
                fin = t_last || dexp;
                if (w[2:0] == 3'b111 || fin) begin
                    exp_segs.push_back({r_seg, 2'b00, 4'(r_open), r_bar});
                    r_open = 0;
                end
                r_act = !fin;
            end
            if (m_write && !m_waitrequest) begin
                chk(exp_segs.size() > 0 && exp_words.size() > 0, "R5",
                    "beat with committed piece", exp_segs.size(), 1);
                if (exp_segs.size() > 0 && exp_words.size() > 0) begin
                    seg_t s;
                    wrd_t x;
                    s = exp_segs[0];
                    x = exp_words.pop_front();
                    chk(m_address == s.a && m_burstcount == s.n && m_bar == s.bar,
                        "R2", "burst address/len/bar", {m_address, m_burstcount},
                        {s.a, s.n});
                    chk(m_writedata == x.d && m_byteenable == x.be, "R7", "data and lanes",
                        {m_byteenable, m_writedata}, {x.be, x.d});
                    chk(32'(m_address[4:2]) + 32'(m_burstcount) <= 8, "R3", "block crossing",
                        32'(m_address[4:2]) + 32'(m_burstcount), 8);
                    if (beat_in_burst == 0) bursts++;
                    beat_in_burst++;
                    if (beat_in_burst == int'(s.n)) begin
                        void'(exp_segs.pop_front());
                        beat_in_burst = 0;
                    end
                end
                popped++;
            end
            prev_hold = m_write && m_waitrequest;
            p_a = m_address; p_n = m_burstcount; p_bar = m_bar;
            p_d = m_writedata; p_be = m_byteenable;
        end
    end

    // offer a burst; stop after a beat that drew a disconnect
    task automatic send(input logic [2:0] bar, input logic [31:0] addr,
                        input logic [3:0] cmd, input int n, input int zidx,
                        input bit first_is_start);
        for (int i = 0; i < n; i++) begin
            bit stop;
            t_valid = 1'b1;
            t_start = first_is_start && (i == 0);
            t_bar = bar; t_addr = addr; t_cmd = cmd;
            t_data = seed; seed = seed + 32'h1111;
            t_be = (i == zidx) ? 4'h0 : 4'(4'hF >> (i % 3));
            t_last = (i == n - 1);
            #1;
            stop = t_disc;
            @(posedge clk); #1;
            if (stop) break;
        end
        t_valid = 1'b0; t_start = 1'b0; t_last = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 3000; k++) begin
            if (exp_segs.size() == 0 && !m_write) break;
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int b0;
        repeat (3) @(posedge clk);
        #1;
        chk(!m_write && !t_disc, "R11", "reset outputs", {m_write, t_disc}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!m_write && !t_disc, "R11", "after reset", {m_write, t_disc}, 0);

        // aligned 8 words, plain memory write
        b0 = bursts;
        send(3'd1, 32'h0000_1000, 4'b0111, 8, -1, 1'b1);
        drain();
        chk(bursts - b0 == 1, "R4", "aligned burst count", bursts - b0, 1);

        // unaligned 10 words, invalidate variant, ends early
        b0 = bursts;
        send(3'd2, 32'h0000_1014, 4'b1111, 10, -1, 1'b1);
        drain();
        chk(bursts - b0 == 2, "R8", "split burst count", bursts - b0, 2);
        chk(bursts - b0 == 2, "R1", "invalidate handled as write", bursts - b0, 2);

        // wrap order: one word, then stray tail beats
        b0 = bursts;
        send(3'd3, 32'h0000_2002, 4'b0111, 4, -1, 1'b1);
        send(3'd3, 32'h0000_2002, 4'b0111, 2, -1, 1'b0);
        drain();
        chk(bursts - b0 == 1, "R6", "wrap burst count", bursts - b0, 1);

        // non-write command is ignored
        b0 = bursts;
        send(3'd0, 32'h0000_5000, 4'b0110, 5, -1, 1'b1);
        drain();
        chk(bursts - b0 == 0 && pushed == popped, "R1", "ignored command", bursts - b0, 0);

        // zero lanes in mid burst, random stalls
        wait_mode = 1;
        b0 = bursts;
        send(3'd4, 32'h0000_3000, 4'b0111, 8, 3, 1'b1);
        drain();
        chk(bursts - b0 == 1, "R7", "zero-lane beat keeps burst", bursts - b0, 1);

        // fill the buffer under a permanent stall, then retry while full
        wait_mode = 2;
        b0 = bursts;
        send(3'd5, 32'h0000_4008, 4'b1111, 20, -1, 1'b1);
        chk(pushed - popped == BUF, "R9", "words taken before disconnect", pushed - popped, BUF);
        send(3'd5, 32'h0000_6000, 4'b0111, 2, -1, 1'b1);
        chk(pushed - popped == BUF, "R9", "beat refused when full", pushed - popped, BUF);
        wait_mode = 1;
        drain();
        chk(bursts - b0 == 3, "R9", "pieces after disconnect", bursts - b0, 3);

        // long burst under random stalls
        send(3'd6, 32'h0000_7004, 4'b0111, 30, 7, 1'b1);
        drain();

        chk(exp_segs.size() == 0 && exp_words.size() == 0, "R5", "all pieces issued",
            exp_segs.size() + exp_words.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule